// File: doc/BRIEF.md
# Poisoned Line Range Tracker

This block keeps a small table of media address ranges known to hold poisoned data. Each range starts on a 64-byte line boundary, spans a whole number of lines and carries a 3-bit poison type. A controller drives one command at a time: inject a single poisoned line, clear a single line, log a multi-line range found by the media itself, or query a window of lines. A query streams back one record for every stored range that overlaps the window, clipped to it, with the type folded into the low address bits.

Clearing a line in the middle of a stored range removes that range and puts back the parts below and above the cleared line. When the table has no room for the upper part, that part is lost and a sticky overflow indication is raised, stamped with the value of a free-running cycle counter. Each command walks the table one entry per cycle and finishes with a single-cycle done pulse carrying a status code.

Top module: `pz_tracker`

## Requirements
- R1: After reset the table is empty, `busy`, `done` and `rec_valid` are low, `rsp_flags` is zero and `ovf_stamp` is zero; a query returns no records.
- R2: Inject (op 0) of a line not covered by a stored range adds a one-line range of type 3'b010 and returns status 0.
- R3: Inject of a line that a stored range already contains returns status 0 and leaves the table unchanged.
- R4: Inject of an uncovered line while all ENTRIES slots are in use returns status 3 and leaves the table unchanged.
- R5: A query (op 2) whose byte address has any of bits 5:0 set returns status 1 and no records.
- R6: A query with start line S (address bits AW-1:6) and length N lines reports exactly the stored ranges with start < S+N and end > S; each record has `rec_addr` = (max(start,S) << 6) | type, bits 5:3 zero, and `rec_lines` = min(end,S+N) - max(start,S), which is never zero.
- R7: A clear (op 1) of line L with L+1 > MEM_LINES returns status 2 and changes nothing.
- R8: A clear of a line that no stored range contains returns status 0 and changes nothing.
- R9: A clear of line L inside range [s,e) removes the range and adds [s,L) when L > s and [L+1,e) when L+1 < e, both with the original type.
- R10: When both parts of a clear are needed and the table is full once the lower part is kept, the upper part is dropped and the overflow bit is set; the bit stays set until reset.
- R11: Log (op 3) adds a range of `cmd_len` lines of type `cmd_type` at the given line; with no free slot it adds nothing, sets the overflow bit and returns status 0.
- R12: A command is taken in a cycle where `cmd_valid` is high and `busy` is low; every command ends with `done` high for exactly one cycle with `status` valid in that cycle.
- R13: `rsp_flags` bit 1 mirrors the overflow bit (other bits zero); `ovf_stamp` holds the cycle counter value from the first overflow and does not change afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when busy is low |
| cmd_op | input | 2 | 0 inject, 1 clear, 2 query, 3 log range |
| cmd_addr | input | AW | Byte address; bits AW-1:6 select the line |
| cmd_len | input | LW | Length in lines (query window or logged range) |
| cmd_type | input | 3 | Poison type for the log operation |
| busy | output | 1 | A command is being processed |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 bad input, 2 bad address, 3 inject table full |
| rec_valid | output | 1 | A query record is present |
| rec_addr | output | AW | Clipped record start address with type in bits 2:0 |
| rec_lines | output | LW | Clipped record length in lines |
| rsp_flags | output | 8 | Bit 1 is the sticky overflow bit |
| ovf_stamp | output | TSW | Cycle count captured at the first overflow |

## Verification
A corrupted table entry or a lost valid bit stays hidden until a later query, which then reports a missing, extra or wrongly clipped record, so the bench follows every state-changing command with queries over the affected window and compares record sets against its own range model. A wrong split on clear shows up as fragments of the wrong length or type on the very next query, and a mistaken slot-availability decision shows as an inject-limit status or an overflow bit that disagrees with the model within the same command. The overflow stamp is checked against the cycle window of the command that caused it.

// File: rtl/pz_pkg.sv
package pz_pkg;

  typedef enum logic [1:0] {
    OP_INJECT = 2'd0,
    OP_CLEAR  = 2'd1,
    OP_QUERY  = 2'd2,
    OP_LOG    = 2'd3
  } pz_op_e;

  localparam logic [1:0] ST_OK        = 2'd0;
  localparam logic [1:0] ST_BAD_INPUT = 2'd1;
  localparam logic [1:0] ST_BAD_ADDR  = 2'd2;
  localparam logic [1:0] ST_INJ_FULL  = 2'd3;

  localparam logic [2:0] INJ_TYPE = 3'b010;

endpackage

// File: rtl/pz_table.sv
// Range storage: data in an inferable memory with a registered read port,
// valid bits in flops so that reset can empty the table in one cycle.
module pz_table #(
  parameter int DEPTH = 16,
  parameter int DW    = 45,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             wr_vld,
  input  logic [IW-1:0]    rd_idx,
  output logic [DW-1:0]    rd_data,
  output logic [DEPTH-1:0] vld
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (wr_en) vld[wr_idx] <= wr_vld;
  end

endmodule

// File: rtl/pz_window.sv
// Overlap, clipping and split arithmetic for one stored range.
module pz_window #(
  parameter int LAW = 26,
  parameter int LW  = 16
) (
  input  logic [LAW-1:0] e_start,
  input  logic [LW-1:0]  e_len,
  input  logic [LAW-1:0] q_start,
  input  logic [LW-1:0]  q_len,
  input  logic [LAW-1:0] line,
  output logic           hit,
  output logic [LAW-1:0] clip_start,
  output logic [LW-1:0]  clip_lines,
  output logic           holds,
  output logic           has_lo,
  output logic [LW-1:0]  lo_len,
  output logic           has_hi,
  output logic [LAW-1:0] hi_start,
  output logic [LW-1:0]  hi_len
);

  logic [LAW:0] e_s, e_end, q_s, q_end, ln, ln1, lo, hi_end;

  always_comb begin
    e_s    = {1'b0, e_start};
    q_s    = {1'b0, q_start};
    ln     = {1'b0, line};
    e_end  = e_s + (LAW+1)'(e_len);
    q_end  = q_s + (LAW+1)'(q_len);
    ln1    = ln + 1'b1;
    hit    = (e_len != '0) && (q_len != '0) && (e_s < q_end) && (e_end > q_s);
    lo     = (e_s > q_s) ? e_s : q_s;
    hi_end = (e_end < q_end) ? e_end : q_end;
    clip_start = lo[LAW-1:0];
    clip_lines = LW'(hi_end - lo);
    holds    = (ln >= e_s) && (ln1 <= e_end);
    has_lo   = ln > e_s;
    lo_len   = LW'(ln - e_s);
    has_hi   = ln1 < e_end;
    hi_start = ln1[LAW-1:0];
    hi_len   = LW'(e_end - ln1);
  end

endmodule

// File: rtl/pz_tracker.sv
module pz_tracker
  import pz_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LW        = 16,
  parameter int ENTRIES   = 16,
  parameter int TSW       = 32,
  parameter int MEM_LINES = 4096
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid,
  input  logic [1:0]     cmd_op,
  input  logic [AW-1:0]  cmd_addr,
  input  logic [LW-1:0]  cmd_len,
  input  logic [2:0]     cmd_type,
  output logic           busy,
  output logic           done,
  output logic [1:0]     status,
  output logic           rec_valid,
  output logic [AW-1:0]  rec_addr,
  output logic [LW-1:0]  rec_lines,
  output logic [7:0]     rsp_flags,
  output logic [TSW-1:0] ovf_stamp
);

  localparam int LAW = AW - 6;
  localparam int IW  = $clog2(ENTRIES);
  localparam int DW  = LAW + LW + 3;
  localparam logic [IW:0]   N_ENT    = (IW+1)'(ENTRIES);
  localparam logic [IW-1:0] LAST_IDX = IW'(ENTRIES - 1);
  localparam logic [LAW:0]  MEM_LIM  = (LAW+1)'(MEM_LINES);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_POST, S_FIX2} st_e;

  st_e             state;
  pz_op_e          op_q;
  logic [LAW-1:0]  line_q;
  logic [LW-1:0]   len_q;
  logic [2:0]      type_q;
  logic [IW:0]     scan_cnt;
  logic            ev_pend;
  logic [IW-1:0]   ev_idx;
  logic            found, free_ok;
  logic [IW-1:0]   found_idx, free_idx;
  logic [LAW-1:0]  f_start, f_hi_start;
  logic [LW-1:0]   f_lo_len, f_hi_len;
  logic [2:0]      f_type;
  logic            f_has_lo, f_has_hi;
  logic            ovf_q;
  logic [TSW-1:0]  tsc;

  // table ports
  logic            wr_en, wr_vld;
  logic [IW-1:0]   wr_idx;
  logic [DW-1:0]   wr_data, rd_data;
  logic [ENTRIES-1:0] tbl_vld;

  pz_table #(.DEPTH(ENTRIES), .DW(DW)) tbl_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_vld(wr_vld), .rd_idx(scan_cnt[IW-1:0]), .rd_data(rd_data), .vld(tbl_vld)
  );

  logic [LAW-1:0] e_start;
  logic [LW-1:0]  e_len;
  logic [2:0]     e_type;
  assign e_start = rd_data[DW-1 -: LAW];
  assign e_len   = rd_data[LW+2 -: LW];
  assign e_type  = rd_data[2:0];

  logic           w_hit, w_holds, w_has_lo, w_has_hi;
  logic [LAW-1:0] w_clip_start, w_hi_start;
  logic [LW-1:0]  w_clip_lines, w_lo_len, w_hi_len;

  pz_window #(.LAW(LAW), .LW(LW)) win_i (
    .e_start(e_start), .e_len(e_len), .q_start(line_q), .q_len(len_q), .line(line_q),
    .hit(w_hit), .clip_start(w_clip_start), .clip_lines(w_clip_lines), .holds(w_holds),
    .has_lo(w_has_lo), .lo_len(w_lo_len), .has_hi(w_has_hi), .hi_start(w_hi_start),
    .hi_len(w_hi_len)
  );

  // completion decisions, made after the scan
  logic       ovf_set, fin, to_fix2;
  logic [1:0] fin_st;

  always_comb begin
    wr_en = 1'b0; wr_idx = found_idx; wr_data = '0; wr_vld = 1'b0;
    ovf_set = 1'b0; fin = 1'b0; to_fix2 = 1'b0; fin_st = ST_OK;
    case (state)
      S_POST: begin
        fin = 1'b1;
        case (op_q)
          OP_INJECT: if (!found) begin
            if (!free_ok) fin_st = ST_INJ_FULL;
            else begin
              wr_en = 1'b1; wr_idx = free_idx; wr_vld = 1'b1;
              wr_data = {line_q, LW'(1), INJ_TYPE};
            end
          end
          OP_LOG: begin
            if (!free_ok) ovf_set = 1'b1;
            else begin
              wr_en = 1'b1; wr_idx = free_idx; wr_vld = 1'b1;
              wr_data = {line_q, len_q, type_q};
            end
          end
          OP_CLEAR: if (found) begin
            wr_en = 1'b1; wr_idx = found_idx;
            if (f_has_lo) begin
              wr_data = {f_start, f_lo_len, f_type}; wr_vld = 1'b1;
              if (f_has_hi) begin fin = 1'b0; to_fix2 = 1'b1; end
            end else if (f_has_hi) begin
              wr_data = {f_hi_start, f_hi_len, f_type}; wr_vld = 1'b1;
            end
          end
          default: ;
        endcase
      end
      S_FIX2: begin
        fin = 1'b1;
        if (free_ok) begin
          wr_en = 1'b1; wr_idx = free_idx; wr_vld = 1'b1;
          wr_data = {f_hi_start, f_hi_len, f_type};
        end else ovf_set = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; busy <= 1'b0; done <= 1'b0; status <= ST_OK;
      rec_valid <= 1'b0; rec_addr <= '0; rec_lines <= '0;
      ovf_q <= 1'b0; ovf_stamp <= '0; tsc <= '0;
      op_q <= OP_INJECT; line_q <= '0; len_q <= '0; type_q <= '0;
      scan_cnt <= '0; ev_pend <= 1'b0; ev_idx <= '0;
      found <= 1'b0; free_ok <= 1'b0; found_idx <= '0; free_idx <= '0;
      f_start <= '0; f_hi_start <= '0; f_lo_len <= '0; f_hi_len <= '0;
      f_type <= '0; f_has_lo <= 1'b0; f_has_hi <= 1'b0;
    end else begin
      tsc <= tsc + 1'b1;
      done <= 1'b0;
      rec_valid <= 1'b0;
      if (ovf_set && !ovf_q) begin
        ovf_q <= 1'b1;
        ovf_stamp <= tsc;
      end
      case (state)
        S_IDLE: if (cmd_valid) begin
          op_q <= pz_op_e'(cmd_op);
          line_q <= cmd_addr[AW-1:6];
          len_q <= cmd_len;
          type_q <= cmd_type;
          scan_cnt <= '0; ev_pend <= 1'b0; found <= 1'b0; free_ok <= 1'b0;
          if (cmd_op == OP_QUERY && cmd_addr[5:0] != 6'd0) begin
            done <= 1'b1; status <= ST_BAD_INPUT;
          end else if (cmd_op == OP_CLEAR && ({1'b0, cmd_addr[AW-1:6]} + 1'b1) > MEM_LIM) begin
            done <= 1'b1; status <= ST_BAD_ADDR;
          end else begin
            state <= S_SCAN; busy <= 1'b1;
          end
        end
        S_SCAN: begin
          if (scan_cnt < N_ENT) begin
            ev_pend <= 1'b1; ev_idx <= scan_cnt[IW-1:0]; scan_cnt <= scan_cnt + 1'b1;
          end else ev_pend <= 1'b0;
          if (ev_pend) begin
            if (!tbl_vld[ev_idx]) begin
              if (!free_ok) begin free_ok <= 1'b1; free_idx <= ev_idx; end
            end else begin
              if (w_holds && !found) begin
                found <= 1'b1; found_idx <= ev_idx;
                f_start <= e_start; f_type <= e_type;
                f_has_lo <= w_has_lo; f_lo_len <= w_lo_len;
                f_has_hi <= w_has_hi; f_hi_start <= w_hi_start; f_hi_len <= w_hi_len;
              end
              if (op_q == OP_QUERY && w_hit) begin
                rec_valid <= 1'b1;
                rec_addr <= {w_clip_start, 3'b000, e_type};
                rec_lines <= w_clip_lines;
              end
            end
            if (ev_idx == LAST_IDX) state <= S_POST;
          end
        end
        S_POST, S_FIX2: begin
          if (to_fix2) state <= S_FIX2;
          else if (fin) begin
            state <= S_IDLE; busy <= 1'b0; done <= 1'b1; status <= fin_st;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign rsp_flags = {6'd0, ovf_q, 1'b0};

  // R12: completion is a single-cycle pulse
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R6: records appear only while a command is in flight, and are well formed
  a_r6_rec_busy: assert property (@(posedge clk) disable iff (rst) rec_valid |-> busy);
  a_r6_rec_shape: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> (rec_lines != '0) && (rec_addr[5:3] == 3'd0));
  // R10: overflow bit is sticky
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst) rsp_flags[1] |=> rsp_flags[1]);
  // R13: stamp frozen once overflow has been seen
  a_r13_stamp_hold: assert property (@(posedge clk) disable iff (rst) rsp_flags[1] |=> $stable(ovf_stamp));
  // R4: inject-limit status only when every slot holds a range
  a_r4_limit_full: assert property (@(posedge clk) disable iff (rst)
    (done && status == ST_INJ_FULL) |-> (&tbl_vld));

endmodule

// File: tb/pz_tracker_tb_top.sv
module pz_tracker_tb_top;
  import pz_pkg::*;

  localparam int AW = 32, LW = 16, ENT = 16, TSW = 32, MEML = 4096;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [LW-1:0] cmd_len = '0;
  logic [2:0] cmd_type = '0;
  logic busy, done, rec_valid;
  logic [1:0] status;
  logic [AW-1:0] rec_addr;
  logic [LW-1:0] rec_lines;
  logic [7:0] rsp_flags;
  logic [TSW-1:0] ovf_stamp;

  always #4 clk = ~clk;

  pz_tracker #(.AW(AW), .LW(LW), .ENTRIES(ENT), .TSW(TSW), .MEM_LINES(MEML)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_type(cmd_type), .busy(busy), .done(done), .status(status),
    .rec_valid(rec_valid), .rec_addr(rec_addr), .rec_lines(rec_lines),
    .rsp_flags(rsp_flags), .ovf_stamp(ovf_stamp)
  );

  int n_chk = 0, n_fail = 0;
  longint cyc = 0;
  always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;

  // reference model: unordered list of ranges
  int m_s[ENT], m_l[ENT], m_t[ENT];
  int m_n = 0;
  bit m_ovf = 0;

  int rx_n;
  longint rx_a[32];
  int rx_l[32];

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_n = 0; m_ovf = 0;
    @(negedge clk);
  endtask

  task automatic do_cmd(int op, longint addr, int len, int typ, output int st);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op[1:0]; cmd_addr = addr[AW-1:0];
    cmd_len = len[LW-1:0]; cmd_type = typ[2:0];
    @(negedge clk);
    cmd_valid = 1'b0;
    rx_n = 0; st = -1;
    for (int k = 0; k < 200; k++) begin
      if (rec_valid) begin
        if (rx_n < 32) begin rx_a[rx_n] = rec_addr; rx_l[rx_n] = rec_lines; end
        rx_n++;
      end
      if (done) begin st = status; break; end
      @(negedge clk);
    end
    if (st < 0) check(0, "R12 done missing", 0, 1);
  endtask

  function automatic int m_find(int ln);
    for (int i = 0; i < m_n; i++)
      if (ln >= m_s[i] && ln < m_s[i] + m_l[i]) return i;
    return -1;
  endfunction

  function automatic void m_add(int s, int l, int t);
    m_s[m_n] = s; m_l[m_n] = l; m_t[m_n] = t; m_n++;
  endfunction

  // expected status of a state-changing op, applied to the model
  function automatic int m_apply(int op, int ln, int len, int typ);
    int i, s, e;
    case (op)
      0: begin
        if (m_find(ln) >= 0) return 0;
        if (m_n == ENT) return 3;
        m_add(ln, 1, 2); return 0;
      end
      3: begin
        if (m_n == ENT) begin m_ovf = 1; return 0; end
        m_add(ln, len, typ); return 0;
      end
      default: begin
        if (ln + 1 > MEML) return 2;
        i = m_find(ln);
        if (i < 0) return 0;
        s = m_s[i]; e = m_s[i] + m_l[i]; typ = m_t[i];
        m_n--; m_s[i] = m_s[m_n]; m_l[i] = m_l[m_n]; m_t[i] = m_t[m_n];
        if (ln > s) m_add(s, ln - s, typ);
        if (ln + 1 < e) begin
          if (m_n == ENT) m_ovf = 1; else m_add(ln + 1, e - ln - 1, typ);
        end
        return 0;
      end
    endcase
  endfunction

  task automatic run_op(int op, int ln, int len, int typ, string req);
    int exp_st, st;
    exp_st = m_apply(op, ln, len, typ);
    do_cmd(op, longint'(ln) << 6, len, typ, st);
    check(st == exp_st, req, st, exp_st);
    check(rsp_flags[1] == m_ovf, {req, " overflow bit"}, rsp_flags[1], m_ovf);
  endtask

  task automatic run_query(longint qaddr, int qlen, string req);
    int st, en, qs, qe, lo, hi, hits;
    longint ea[ENT];
    int el[ENT];
    bit used[32];
    do_cmd(2, qaddr, qlen, 0, st);
    if (qaddr[5:0] != 0) begin
      check(st == 1 && rx_n == 0, {req, " unaligned query"}, st * 100 + rx_n, 100);
      return;
    end
    qs = int'(qaddr >> 6); qe = qs + qlen; en = 0;
    for (int i = 0; i < m_n; i++) begin
      if (qlen > 0 && m_s[i] < qe && m_s[i] + m_l[i] > qs) begin
        lo = (m_s[i] > qs) ? m_s[i] : qs;
        hi = (m_s[i] + m_l[i] < qe) ? m_s[i] + m_l[i] : qe;
        ea[en] = (longint'(lo) << 6) | m_t[i]; el[en] = hi - lo; en++;
      end
    end
    check(st == 0 && rx_n == en, {req, " record count"}, rx_n, en);
    hits = 0;
    for (int j = 0; j < 32; j++) used[j] = 0;
    for (int i = 0; i < en; i++)
      for (int j = 0; j < rx_n && j < 32; j++)
        if (!used[j] && rx_a[j] == ea[i] && rx_l[j] == el[i]) begin used[j] = 1; hits++; break; end
    check(hits == en, {req, " record contents"}, hits, en);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R12 watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    longint c0, c1;
    void'($urandom(32'd1234));
    do_reset();
    // R1 reset state
    check(busy == 0 && done == 0 && rec_valid == 0, "R1 idle outputs", {busy, done, rec_valid}, 0);
    check(rsp_flags == 0 && ovf_stamp == 0, "R1 overflow clear", rsp_flags, 0);
    run_query(0, 200, "R1 empty query");

    // R11 log a range, R6 clipping
    run_op(3, 100, 10, 5, "R11 log range");
    run_query(longint'(96) << 6, 16, "R6 full cover");
    run_query(longint'(104) << 6, 3, "R6 inner clip");
    run_query(longint'(90) << 6, 12, "R6 head clip");
    run_query(longint'(110) << 6, 5, "R6 touch end no overlap");

    // R9 split into two parts
    run_op(1, 104, 0, 0, "R9 clear middle");
    run_query(longint'(96) << 6, 20, "R9 fragments");
    // R3 covered inject
    run_op(0, 101, 0, 0, "R3 covered inject");
    run_query(longint'(96) << 6, 20, "R3 unchanged");
    // R7, R5, R8
    run_op(1, MEML, 0, 0, "R7 clear past memory");
    run_query((longint'(100) << 6) + 8, 4, "R5");
    run_op(1, 50, 0, 0, "R8 clear uncovered");
    run_query(0, 200, "R8 unchanged");

    // fill table, then R4 and R10
    run_op(3, 200, 8, 1, "R11 second range");
    for (int i = 10; i < 23; i++) run_op(0, i, 0, 0, "R2 inject");
    run_query(0, 30, "R2 injected lines");
    run_op(0, 30, 0, 0, "R4 inject limit");
    run_query(longint'(28) << 6, 4, "R4 unchanged");
    c0 = cyc;
    run_op(1, 203, 0, 0, "R10 clear while full");
    c1 = cyc;
    check(rsp_flags[1] == 1'b1, "R10 overflow set", rsp_flags[1], 1);
    check(longint'(ovf_stamp) >= c0 && longint'(ovf_stamp) <= c1, "R13 stamp window", ovf_stamp, c0);
    run_query(longint'(200) << 6, 8, "R10 upper dropped");
    c0 = longint'(ovf_stamp);
    run_op(1, 13, 0, 0, "R10 later clear");
    check(rsp_flags[1] == 1'b1 && longint'(ovf_stamp) == c0, "R13 stamp held", ovf_stamp, c0);

    // R11 log with no room
    do_reset();
    check(rsp_flags == 0, "R1 flags after reset", rsp_flags, 0);
    for (int i = 0; i < 16; i++) run_op(0, i, 0, 0, "R2 fill");
    run_op(3, 40, 4, 6, "R11 log when full");
    run_query(longint'(40) << 6, 4, "R11 nothing added");

    // random mix
    do_reset();
    for (int n = 0; n < 400; n++) begin
      int r, ln, ql;
      longint qa;
      r = int'($urandom % 10);
      ln = int'($urandom % 48);
      if (r < 4) run_op(0, ln, 0, 0, "R2 random inject");
      else if (r < 7) begin
        if ($urandom % 16 == 0) ln = MEML + ln;
        run_op(1, ln, 0, 0, "R9 random clear");
      end else begin
        ql = int'($urandom % 20);
        qa = longint'(ln) << 6;
        if ($urandom % 8 == 0) qa = qa + 1 + ($urandom % 63);
        run_query(qa, ql, "R6 random query");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule